// File: doc/BRIEF.md
# SPI Bus Pause Controller

This block sits between the pins of an SPI slave and the slave's own shift logic and adds a pause function. A master can halt a transfer in the middle of a byte by pulling the pause input low, do other work on the shared bus, and later release the pause. The slave then carries on from the exact bit where it stopped. The master must keep chip select low while paused. If chip select rises during a pause, the transaction is thrown away and the slave is reset.

All pin inputs are synchronised into the system clock. The block detects the SCK edges and passes two qualifier pulses to the slave: `bit_valid` marks each SCK rise and carries the SI bit, and `shift_fall` marks each SCK fall, where the slave moves its next output bit. While paused, both pulses are suppressed and the serial output pad is released. Because the slave's shift state never advances during a pause, the bit it was presenting comes back on the pad after release.

Entry into and exit from the pause happen only while SCK is low, so a bit is never split. A pause request made while SCK is high waits until SCK falls, and that falling edge still reaches the slave. A release made while SCK is high also waits for SCK to fall, and that falling edge is swallowed. The controller has five states:
- `ST_IDLE`: chip select is high and the slave is held in reset.
- `ST_RUN`: normal transfer.
- `ST_HOLD_WAIT`: a pause was requested while SCK was high.
- `ST_HELD`: paused.
- `ST_RESUME_WAIT`: a release was requested while SCK was high.

The transitions are:
- `ST_IDLE` to `ST_RUN` when CS falls.
- `ST_RUN` to `ST_HELD` when the pause input is low and SCK is low.
- `ST_RUN` to `ST_HOLD_WAIT` when the pause input is low and SCK is high.
- `ST_HOLD_WAIT` to `ST_HELD` when SCK falls.
- `ST_HOLD_WAIT` to `ST_RUN` when the pause input rises again (cancel).
- `ST_HELD` to `ST_RUN` when the pause input is high and SCK is low.
- `ST_HELD` to `ST_RESUME_WAIT` when the pause input is high and SCK is high.
- `ST_RESUME_WAIT` to `ST_RUN` when SCK falls.
- `ST_RESUME_WAIT` to `ST_HELD` when the pause input drops again.
- Any state to `ST_IDLE` when CS is high.

Top module: `spi_hold_ctrl`

## Requirements
- R1: With CS low and no pause, every SCK rise gives exactly one `bit_valid` pulse with `si_bit` equal to SI, and every SCK fall gives exactly one `shift_fall` pulse. Pulses appear SYNC_STAGES clock cycles after the pin change.
- R2: While CS is high and after reset, `slv_rst` is 1, and `bit_valid`, `shift_fall` and `pad_so_oe` are 0.
- R3: Taking `hold_n` low while SCK is low enters the pause. While paused, SCK and SI activity produces no `bit_valid` or `shift_fall` pulse.
- R4: Taking `hold_n` high while SCK is low ends the pause. The bits sent before and after the pause form one unbroken byte, and `pad_so` again shows the bit that was pending before the pause.
- R5: `pad_so_oe` is 0 during a pause. Otherwise, with CS low, it equals `slv_so_en`. `pad_so` equals `slv_so` when driven and 0 when not driven.
- R6: Taking `hold_n` low while SCK is high defers the pause. The SCK fall that ends that bit still produces a `shift_fall` pulse, and the pause starts once SCK is low.
- R7: Taking `hold_n` high while SCK is high during a pause keeps the pause and `pad_so_oe` low. The SCK fall is swallowed, and the transfer resumes once SCK is low.
- R8: CS rising during a pause resets the slave through `slv_rst`. The next CS low starts a fresh transaction from bit 7 that is not paused while `hold_n` is high.
- R9: A `hold_n` low pulse that begins and ends while SCK stays high causes no pause, and the transfer runs without losing a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select pin, active low |
| sck | input | 1 | Serial clock pin (idle low) |
| si | input | 1 | Serial data input pin |
| hold_n | input | 1 | Pause request pin, active low |
| slv_so | input | 1 | Output bit presented by the slave |
| slv_so_en | input | 1 | Slave wants the output pad driven |
| bit_valid | output | 1 | One-cycle pulse per qualified SCK rise |
| si_bit | output | 1 | Synchronised SI, valid with `bit_valid` |
| shift_fall | output | 1 | One-cycle pulse per qualified SCK fall |
| pad_so | output | 1 | Serial output pad value |
| pad_so_oe | output | 1 | Serial output pad drive enable |
| slv_rst | output | 1 | Reset to the slave shift logic |

## Verification
The case where two functions meet in one cycle is a deferred pause entry. The SCK fall that completes the current bit must reach the slave as `shift_fall`, and the state must move to `ST_HELD` in that same cycle. The bench provokes this by dropping `hold_n` while SCK is high, then toggling SCK during the pause and releasing it while SCK is high. It judges the result by three things:
- the transaction yields exactly eight `shift_fall` pulses;
- the received byte is intact;
- the pad shows the pending bit after release.

A cancelled request, where `hold_n` dips and recovers within one SCK high phase, is checked the same way.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

    // Controller states: idle, running, waiting to pause, paused, waiting to resume
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_HOLD_WAIT,
        ST_HELD,
        ST_RESUME_WAIT
    } hold_state_t;

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
    parameter int                WIDTH   = 4,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    generate
        if (STAGES <= 1) begin : g_single
            logic [WIDTH-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= din;
            end
            assign dout = q;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], din};
            end
            assign dout = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);

    logic level_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    assign rise = level & ~level_d;
    assign fall = ~level & level_d;

endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
    import spi_hold_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n_s,
    input  logic        sck_s,
    input  logic        hold_n_s,
    output hold_state_t state,
    output logic        pass_edges,
    output logic        drive_ok,
    output logic        slave_rst
);

    hold_state_t state_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions: pause entry and exit only at SCK low, CS high aborts
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (!cs_n_s) state_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (cs_n_s)         state_nxt = ST_IDLE;
                else if (!hold_n_s) state_nxt = sck_s ? ST_HOLD_WAIT : ST_HELD;
            end
            ST_HOLD_WAIT: begin
                if (cs_n_s)         state_nxt = ST_IDLE;
                else if (hold_n_s)  state_nxt = ST_RUN;
                else if (!sck_s)    state_nxt = ST_HELD;
            end
            ST_HELD: begin
                if (cs_n_s)         state_nxt = ST_IDLE;
                else if (hold_n_s)  state_nxt = sck_s ? ST_RESUME_WAIT : ST_RUN;
            end
            ST_RESUME_WAIT: begin
                if (cs_n_s)         state_nxt = ST_IDLE;
                else if (!hold_n_s) state_nxt = ST_HELD;
                else if (!sck_s)    state_nxt = ST_RUN;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        pass_edges = 1'b0;
        drive_ok   = 1'b0;
        slave_rst  = 1'b0;
        unique case (state)
            ST_IDLE:        slave_rst  = 1'b1;
            ST_RUN, ST_HOLD_WAIT: begin
                pass_edges = 1'b1;
                drive_ok   = 1'b1;
            end
            ST_HELD, ST_RESUME_WAIT: begin
                pass_edges = 1'b0;
                drive_ok   = 1'b0;
            end
            default:        slave_rst  = 1'b1;
        endcase
    end

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
    import spi_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic slv_so,
    input  logic slv_so_en,
    output logic bit_valid,
    output logic si_bit,
    output logic shift_fall,
    output logic pad_so,
    output logic pad_so_oe,
    output logic slv_rst
);

    localparam int          PIN_COUNT = 4;
    // bit order: {hold_n, si, sck, cs_n}; idle levels hold_n=1, cs_n=1
    localparam logic [PIN_COUNT-1:0] PIN_IDLE = 4'b1001;

    logic [PIN_COUNT-1:0] pins_s;
    logic                 cs_n_s;
    logic                 sck_s;
    logic                 si_s;
    logic                 hold_n_s;
    logic                 sck_rise;
    logic                 sck_fall;
    logic                 pass_edges;
    logic                 drive_ok;
    logic                 slave_rst;
    hold_state_t          fsm_state;

    spi_hold_sync #(
        .WIDTH   (PIN_COUNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({hold_n, si, sck, cs_n}),
        .dout  (pins_s)
    );

    assign cs_n_s   = pins_s[0];
    assign sck_s    = pins_s[1];
    assign si_s     = pins_s[2];
    assign hold_n_s = pins_s[3];

    spi_hold_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sck_s),
        .rise  (sck_rise),
        .fall  (sck_fall)
    );

    spi_hold_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_s     (cs_n_s),
        .sck_s      (sck_s),
        .hold_n_s   (hold_n_s),
        .state      (fsm_state),
        .pass_edges (pass_edges),
        .drive_ok   (drive_ok),
        .slave_rst  (slave_rst)
    );

    assign bit_valid  = sck_rise & pass_edges;
    assign si_bit     = si_s;
    assign shift_fall = sck_fall & pass_edges;
    assign pad_so_oe  = slv_so_en & drive_ok;
    assign pad_so     = slv_so & pad_so_oe;
    assign slv_rst    = slave_rst;

endmodule

// File: rtl/spi_hold_chk.sv
module spi_hold_chk
    import spi_hold_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  hold_state_t state,
    input  logic        cs_n_s,
    input  logic        sck_s,
    input  logic        hold_n_s,
    input  logic        bit_valid,
    input  logic        shift_fall,
    input  logic        pad_so_oe,
    input  logic        slv_rst
);

    logic paused;
    assign paused = (state == ST_HELD) || (state == ST_RESUME_WAIT);

    p_quiet_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slv_rst |-> (!bit_valid && !shift_fall && !pad_so_oe));

    p_gate_in_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> (!bit_valid && !shift_fall));

    p_resume_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && !cs_n_s && hold_n_s && !sck_s) |=> (state == ST_RUN));

    p_so_off_in_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> !pad_so_oe);

    p_defer_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD_WAIT && !cs_n_s && !hold_n_s && sck_s) |=> (state == ST_HOLD_WAIT));

    p_defer_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESUME_WAIT && !cs_n_s && hold_n_s && sck_s) |=> (state == ST_RESUME_WAIT));

    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> slv_rst);

endmodule

bind spi_hold_ctrl spi_hold_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (fsm_state),
    .cs_n_s     (cs_n_s),
    .sck_s      (sck_s),
    .hold_n_s   (hold_n_s),
    .bit_valid  (bit_valid),
    .shift_fall (shift_fall),
    .pad_so_oe  (pad_so_oe),
    .slv_rst    (slv_rst)
);

// File: tb/spi_hold_ctrl_test.sv
module spi_hold_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;   // clock cycles per SCK phase

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic hold_n = 1'b1;
    logic slv_so_en = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic [2:0] tx_idx = 3'd0;
    logic slv_so;

    logic bit_valid, si_bit, shift_fall, pad_so, pad_so_oe, slv_rst;

    assign slv_so = tx_byte[3'd7 - tx_idx];

    spi_hold_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sck        (sck),
        .si         (si),
        .hold_n     (hold_n),
        .slv_so     (slv_so),
        .slv_so_en  (slv_so_en),
        .bit_valid  (bit_valid),
        .si_bit     (si_bit),
        .shift_fall (shift_fall),
        .pad_so     (pad_so),
        .pad_so_oe  (pad_so_oe),
        .slv_rst    (slv_rst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_tag = "R1";
    logic [7:0] exp_q[$];
    logic [7:0] rx_sh = 8'h00;
    int rx_cnt = 0;
    int fall_cnt = 0;
    int valid_cnt = 0;

    task automatic check_eq(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: rebuilds bytes from qualifier pulses and pops the scoreboard
    always @(negedge clk) begin
        if (slv_rst) begin
            rx_cnt = 0;
            tx_idx = 3'd0;
        end else begin
            if (bit_valid) begin
                valid_cnt++;
                rx_sh = {rx_sh[6:0], si_bit};
                rx_cnt++;
                if (rx_cnt == 8) begin
                    rx_cnt = 0;
                    if (exp_q.size() == 0) begin
                        check_eq({cur_tag, " unexpected byte"}, int'(rx_sh), 0);
                    end else begin
                        check_eq({cur_tag, " scoreboard byte"}, int'(rx_sh), int'(exp_q.pop_front()));
                    end
                end
            end
            if (shift_fall) begin
                fall_cnt++;
                tx_idx = tx_idx + 3'd1;
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b);
        si = b;
        wait_clk(HALF);
        sck = 1'b1;
        wait_clk(HALF);
        sck = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] d, input int from, input int upto);
        for (int i = from; i < upto; i++) send_bit(d[7-i]);
    endtask

    task automatic start_xfer(input logic [7:0] rx_exp, input logic [7:0] tx);
        exp_q.push_back(rx_exp);
        tx_byte = tx;
        slv_so_en = 1'b1;
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic end_xfer;
        wait_clk(HALF);
        cs_n = 1'b1;
        slv_so_en = 1'b0;
        wait_clk(HALF);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int base;
        int vbase;
        logic pend;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);

        // R2: reset and idle state
        check_eq("R2 slv_rst idle", slv_rst, 1);
        check_eq("R2 oe idle", pad_so_oe, 0);
        check_eq("R2 bit_valid idle", bit_valid, 0);

        // R1, R5: plain byte without pause
        cur_tag = "R1";
        base = fall_cnt;
        start_xfer(8'hA5, 8'h5A);
        check_eq("R5 first out bit", pad_so, 0);
        check_eq("R5 oe follows en", pad_so_oe, 1);
        send_bits(8'hA5, 0, 8);
        end_xfer();
        check_eq("R1 fall count", fall_cnt - base, 8);

        // R3, R4, R5: pause entered and left at SCK low
        cur_tag = "R4";
        base = fall_cnt;
        start_xfer(8'h3C, 8'hC6);
        send_bits(8'h3C, 0, 3);
        hold_n = 1'b0;
        wait_clk(HALF);
        check_eq("R5 oe off in pause", pad_so_oe, 0);
        pend = tx_byte[4];
        vbase = valid_cnt;
        for (int k = 0; k < 2; k++) begin
            si = ~si;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
            wait_clk(HALF);
        end
        check_eq("R3 no rise pulses in pause", valid_cnt - vbase, 0);
        check_eq("R3 no fall pulses in pause", fall_cnt - base, 3);
        hold_n = 1'b1;
        wait_clk(HALF);
        check_eq("R4 oe restored", pad_so_oe, 1);
        check_eq("R4 pending bit on pad", pad_so, pend);
        send_bits(8'h3C, 3, 8);
        end_xfer();
        check_eq("R4 fall count", fall_cnt - base, 8);

        // R6, R7: pause requested and released while SCK high
        cur_tag = "R6 R7";
        base = fall_cnt;
        start_xfer(8'h69, 8'hB2);
        send_bits(8'h69, 0, 2);
        si = 1'b1;               // bit 2 of 0x69
        wait_clk(HALF);
        sck = 1'b1;
        wait_clk(2);
        hold_n = 1'b0;
        wait_clk(HALF);
        sck = 1'b0;
        wait_clk(HALF);
        check_eq("R6 fall before pause passed", fall_cnt - base, 3);
        check_eq("R6 oe off after deferred entry", pad_so_oe, 0);
        sck = 1'b1;
        wait_clk(HALF);
        hold_n = 1'b1;
        wait_clk(HALF);
        check_eq("R7 still paused at SCK high", pad_so_oe, 0);
        sck = 1'b0;
        wait_clk(HALF);
        check_eq("R7 resumed at SCK low", pad_so_oe, 1);
        check_eq("R7 pending bit on pad", pad_so, tx_byte[4]);
        send_bits(8'h69, 3, 8);
        end_xfer();
        check_eq("R7 fall count", fall_cnt - base, 8);

        // R8: CS rises during pause, then fresh transaction
        cur_tag = "R8";
        tx_byte = 8'hFF;
        slv_so_en = 1'b1;
        cs_n = 1'b0;
        wait_clk(HALF);
        send_bits(8'h0F, 0, 4);
        hold_n = 1'b0;
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(HALF);
        check_eq("R8 slave reset on abort", slv_rst, 1);
        hold_n = 1'b1;
        start_xfer(8'h96, 8'h4D);
        check_eq("R8 fresh start bit 7", pad_so, 0);
        check_eq("R8 not paused", pad_so_oe, 1);
        send_bits(8'h96, 0, 8);
        end_xfer();

        // R9: pause request cancelled within one SCK high phase
        cur_tag = "R9";
        base = fall_cnt;
        start_xfer(8'hD2, 8'h81);
        send_bits(8'hD2, 0, 2);
        si = 1'b0;               // bit 2 of 0xD2
        wait_clk(HALF);
        sck = 1'b1;
        wait_clk(2);
        hold_n = 1'b0;
        wait_clk(HALF);
        hold_n = 1'b1;
        wait_clk(HALF);
        sck = 1'b0;
        wait_clk(HALF);
        check_eq("R9 no pause", pad_so_oe, 1);
        send_bits(8'hD2, 3, 8);
        end_xfer();
        check_eq("R9 fall count", fall_cnt - base, 8);

        check_eq("R1 scoreboard drained", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule